// File: doc/BRIEF.md
# Disk Controller Host Command Port

This block is the host-facing port of a small hard-disk controller. The host sees four byte-wide registers at consecutive offsets. Writing the select register opens a command phase. The host then writes a six-byte command block into the data register, one byte each time the status register shows the controller ready for a byte. After the last byte the controller goes busy while a fixed-latency sequencer stands in for the drive-side work. It then enters a status phase in which the host reads one to four result bytes back through the same data register.

The status register tells the host what to do next. A set request bit means a byte transfer is expected. The direction bit shows whether that byte flows from the controller to the host. The phase bit marks command or result transfer, and the busy bit covers the whole exchange. Two more bits flag a DMA request while a read or write executes and an interrupt at completion, each gated by the enable register. Media access, sector buffering and ECC computation are not modelled. The sequencer derives its result codes from the command fields alone.

Top module: `dkc_host_port`

## Requirements
- R1: After reset the status register (offset 1) reads 0x00 and both the irq and drq outputs are low.
- R2: A write to offset 2 in any phase starts a new command phase on the next cycle. The status then reads 0x0D: request bit 0, phase bit 2 and busy bit 3 set, direction bit 1 clear. Any pending interrupt is dropped.
- R3: Each data write (offset 0) in the command phase takes one command byte. The sixth byte moves the block to execution. Status then reads busy only (0x08, plus bit 4 when a DMA request is active) for exactly EXEC_CYCLES cycles. After that it reads 0x0F: request, direction, phase and busy set.
- R4: Offset 3 holds the enable mask, where bit 0 enables DMA and bit 1 enables the interrupt (3 = both, 2 = interrupt only, 0 = neither). Status bit 5 and the irq output are set on entering the status phase only if mask bit 1 is set at that moment.
- R5: During execution of opcode 0x08 (read) or 0x0A (write), status bit 4 and the drq output are high while mask bit 0 is set. They are low during every other phase and for every other opcode.
- R6: Opcodes 0x01 (recalibrate), 0x0C (specify), 0x08 and 0x0A return one result byte holding a 6-bit error code: 0x00 for success and 0x21 when the sector field (low 6 bits of command byte 2) is not below NUM_SECTORS for 0x08 or 0x0A. Any opcode not listed in R6 to R8 returns the single byte 0x20.
- R7: A read (0x08) whose sector field equals ECC_SECTOR returns error code 0x18 (decimal 24, correctable data error). Opcode 0x0D returns two bytes: ECC_LEN, then 0x00.
- R8: Opcode 0x03 (sense) returns four bytes: the error code of the last non-sense command, then bytes 1, 2 and 3 of that command. Before any such command the error code and argument bytes read as 0x00.
- R9: In the status phase each data read returns the current result byte and advances to the next. A read of the final byte returns the block to idle, with status 0x00 and irq low.
- R10: Data writes outside the command phase and data reads outside the status phase have no effect. Data reads outside the status phase return 0x00, and reads of offsets 2 and 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register offset: 0 data, 1 status, 2 select, 3 enable mask |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (advances result bytes at offset 0) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for the addressed register |
| irq | output | 1 | Completion interrupt (status bit 5) |
| drq | output | 1 | DMA request (status bit 4) |

## Verification
The bench attacks the exact length of the busy window. A design that is off by one on the execution counter shows the request bit a cycle early or late against the model. It also covers the ECC-error path followed by an ECC-length read and a sense. A design that updates its saved error on sense, or keeps the wrong argument bytes, returns stale bytes. Select is written in the middle of execution to check that a new command phase replaces the old work instead of letting it complete. A stray data write during the status phase and a data read during the command phase are issued to show that neither moves the byte pointer or phase. An interrupt mask changed between commands shows whether the irq bit is taken from the mask at completion time.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
   localparam int CMD_BYTES   = 6;
   localparam int ARG_KEEP    = 4;
   localparam int MAX_RESULTS = 4;

   localparam logic [1:0] OFS_DATA = 2'd0;
   localparam logic [1:0] OFS_STAT = 2'd1;
   localparam logic [1:0] OFS_SEL  = 2'd2;
   localparam logic [1:0] OFS_MASK = 2'd3;

   localparam logic [7:0] OP_RECAL  = 8'h01;
   localparam logic [7:0] OP_SENSE  = 8'h03;
   localparam logic [7:0] OP_READ   = 8'h08;
   localparam logic [7:0] OP_WRITE  = 8'h0A;
   localparam logic [7:0] OP_SPEC   = 8'h0C;
   localparam logic [7:0] OP_ECCLEN = 8'h0D;

   localparam logic [5:0] ERR_NONE   = 6'h00;
   localparam logic [5:0] ERR_CORR   = 6'h18;
   localparam logic [5:0] ERR_BADCMD = 6'h20;
   localparam logic [5:0] ERR_RANGE  = 6'h21;

   localparam int ST_REQ  = 0;
   localparam int ST_DIR  = 1;
   localparam int ST_PHS  = 2;
   localparam int ST_BUSY = 3;
   localparam int ST_DRQ  = 4;
   localparam int ST_IRQ  = 5;

   typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_EXEC, PH_STAT} phase_t;
   typedef logic [ARG_KEEP-1:0][7:0]    arg_blk_t;
   typedef logic [MAX_RESULTS-1:0][7:0] res_blk_t;
endpackage

// File: rtl/dkc_regs.sv
module dkc_regs
   import dkc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] addr,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [1:0] mask_din,
   output logic       data_wr,
   output logic       data_rd,
   output logic       sel_wr,
   output logic [1:0] mask_q
);
   assign data_wr = wr_en && (addr == OFS_DATA);
   assign data_rd = rd_en && (addr == OFS_DATA);
   assign sel_wr  = wr_en && (addr == OFS_SEL);

   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_q <= 2'b00;
      else if (wr_en && (addr == OFS_MASK))
         mask_q <= mask_din;
   end
endmodule

// File: rtl/dkc_result.sv
module dkc_result
   import dkc_pkg::*;
#(
   parameter int NUM_SECTORS = 17,
   parameter int ECC_SECTOR  = 5,
   parameter int ECC_LEN     = 11
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     done,
   input  arg_blk_t args,
   output res_blk_t res_q,
   output logic [$clog2(MAX_RESULTS+1)-1:0] res_n_q
);
   localparam int RNW = $clog2(MAX_RESULTS+1);

   logic [5:0]         last_err_q;
   logic [2:0][7:0]    last_arg_q;
   logic [5:0]         err_c;
   logic [5:0]         sec_c;
   res_blk_t           res_c;
   logic [RNW-1:0]     n_c;
   logic               keep_c;

   assign sec_c = args[2][5:0];

   always_comb begin
      err_c  = ERR_NONE;
      res_c  = '0;
      n_c    = RNW'(1);
      keep_c = 1'b1;
      case (args[0])
         OP_RECAL, OP_SPEC: err_c = ERR_NONE;
         OP_READ, OP_WRITE: begin
            if (int'(sec_c) >= NUM_SECTORS)
               err_c = ERR_RANGE;
            else if ((args[0] == OP_READ) && (int'(sec_c) == ECC_SECTOR))
               err_c = ERR_CORR;
         end
         OP_SENSE: begin
            keep_c = 1'b0;
            n_c    = RNW'(4);
         end
         OP_ECCLEN: n_c = RNW'(2);
         default:   err_c = ERR_BADCMD;
      endcase
      if (args[0] == OP_SENSE) begin
         res_c[0] = {2'b00, last_err_q};
         res_c[1] = last_arg_q[0];
         res_c[2] = last_arg_q[1];
         res_c[3] = last_arg_q[2];
      end else if (args[0] == OP_ECCLEN) begin
         res_c[0] = 8'(ECC_LEN);
      end else begin
         res_c[0] = {2'b00, err_c};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q      <= '0;
         res_n_q    <= RNW'(1);
         last_err_q <= ERR_NONE;
         last_arg_q <= '0;
      end else if (done) begin
         res_q   <= res_c;
         res_n_q <= n_c;
         if (keep_c) begin
            last_err_q <= err_c;
            last_arg_q <= {args[3], args[2], args[1]};
         end
      end
   end
endmodule

// File: rtl/dkc_seq.sv
module dkc_seq
   import dkc_pkg::*;
#(
   parameter int EXEC_CYCLES = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       data_wr,
   input  logic       data_rd,
   input  logic       sel_wr,
   input  logic [7:0] wdata,
   input  logic [1:0] mask,
   input  logic [$clog2(MAX_RESULTS+1)-1:0] res_n,
   output phase_t     phase_o,
   output arg_blk_t   args_o,
   output logic       done_o,
   output logic [$clog2(MAX_RESULTS)-1:0] ridx_o,
   output logic [7:0] status_o
);
   localparam int EW  = $clog2(EXEC_CYCLES+1);
   localparam int BW  = $clog2(CMD_BYTES);
   localparam int RW  = $clog2(MAX_RESULTS);
   localparam int RNW = $clog2(MAX_RESULTS+1);

   phase_t          phase_q;
   logic [BW-1:0]   bidx_q;
   logic [EW-1:0]   ecnt_q;
   logic [RW-1:0]   ridx_q;
   logic            irq_q;
   logic            take_c;
   logic            last_rd_c;
   logic            is_rw_c;

   assign take_c    = (phase_q == PH_CMD) && data_wr;
   assign done_o    = (phase_q == PH_EXEC) && (ecnt_q == '0);
   assign last_rd_c = (RNW'(ridx_q) + RNW'(1)) == res_n;
   assign is_rw_c   = (args_o[0] == OP_READ) || (args_o[0] == OP_WRITE);

   for (genvar g = 0; g < CMD_BYTES; g++) begin : g_byte
      if (g < ARG_KEEP) begin : g_keep
         always_ff @(posedge clk) begin
            if (!rst_n)
               args_o[g] <= 8'h00;
            else if (take_c && (bidx_q == BW'(g)))
               args_o[g] <= wdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         bidx_q  <= '0;
         ecnt_q  <= '0;
         ridx_q  <= '0;
         irq_q   <= 1'b0;
      end else if (sel_wr) begin
         phase_q <= PH_CMD;
         bidx_q  <= '0;
         irq_q   <= 1'b0;
      end else begin
         case (phase_q)
            PH_CMD: if (data_wr) begin
               if (bidx_q == BW'(CMD_BYTES-1)) begin
                  phase_q <= PH_EXEC;
                  ecnt_q  <= EW'(EXEC_CYCLES-1);
               end
               bidx_q <= bidx_q + BW'(1);
            end
            PH_EXEC: begin
               if (ecnt_q == '0) begin
                  phase_q <= PH_STAT;
                  ridx_q  <= '0;
                  irq_q   <= mask[1];
               end else begin
                  ecnt_q <= ecnt_q - EW'(1);
               end
            end
            PH_STAT: if (data_rd) begin
               if (last_rd_c) begin
                  phase_q <= PH_IDLE;
                  irq_q   <= 1'b0;
               end else begin
                  ridx_q <= ridx_q + RW'(1);
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      status_o          = 8'h00;
      status_o[ST_REQ]  = (phase_q == PH_CMD) || (phase_q == PH_STAT);
      status_o[ST_DIR]  = (phase_q == PH_STAT);
      status_o[ST_PHS]  = (phase_q == PH_CMD) || (phase_q == PH_STAT);
      status_o[ST_BUSY] = (phase_q != PH_IDLE);
      status_o[ST_DRQ]  = (phase_q == PH_EXEC) && mask[0] && is_rw_c;
      status_o[ST_IRQ]  = irq_q;
   end

   assign phase_o = phase_q;
   assign ridx_o  = ridx_q;
endmodule

// File: rtl/dkc_host_port.sv
module dkc_host_port
   import dkc_pkg::*;
#(
   parameter int EXEC_CYCLES = 8,
   parameter int NUM_SECTORS = 17,
   parameter int ECC_SECTOR  = 5,
   parameter int ECC_LEN     = 11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] addr,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       irq,
   output logic       drq
);
   localparam int RW  = $clog2(MAX_RESULTS);
   localparam int RNW = $clog2(MAX_RESULTS+1);

   if (EXEC_CYCLES < 1) begin : g_bad_exec
      $error("EXEC_CYCLES must be at least 1");
   end
   if ((NUM_SECTORS < 1) || (NUM_SECTORS > 64)) begin : g_bad_sec
      $error("NUM_SECTORS must fit the 6-bit sector field");
   end
   if ((ECC_SECTOR < 0) || (ECC_SECTOR >= NUM_SECTORS)) begin : g_bad_ecc
      $error("ECC_SECTOR must be a valid sector");
   end
   if ((ECC_LEN < 0) || (ECC_LEN > 255)) begin : g_bad_len
      $error("ECC_LEN must fit one byte");
   end

   logic           data_wr_w, data_rd_w, sel_wr_w, done_w;
   logic [1:0]     mask_w;
   logic [7:0]     status_w;
   phase_t         phase_w;
   arg_blk_t       args_w;
   res_blk_t       res_w;
   logic [RNW-1:0] res_n_w;
   logic [RW-1:0]  ridx_w;

   dkc_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .mask_din (wdata[1:0]),
      .data_wr  (data_wr_w),
      .data_rd  (data_rd_w),
      .sel_wr   (sel_wr_w),
      .mask_q   (mask_w)
   );

   dkc_seq #(.EXEC_CYCLES(EXEC_CYCLES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_wr  (data_wr_w),
      .data_rd  (data_rd_w),
      .sel_wr   (sel_wr_w),
      .wdata    (wdata),
      .mask     (mask_w),
      .res_n    (res_n_w),
      .phase_o  (phase_w),
      .args_o   (args_w),
      .done_o   (done_w),
      .ridx_o   (ridx_w),
      .status_o (status_w)
   );

   dkc_result #(
      .NUM_SECTORS (NUM_SECTORS),
      .ECC_SECTOR  (ECC_SECTOR),
      .ECC_LEN     (ECC_LEN)
   ) u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .done    (done_w && !sel_wr_w),
      .args    (args_w),
      .res_q   (res_w),
      .res_n_q (res_n_w)
   );

   always_comb begin
      case (addr)
         OFS_DATA: rdata = (phase_w == PH_STAT) ? res_w[ridx_w] : 8'h00;
         OFS_STAT: rdata = status_w;
         default:  rdata = 8'h00;
      endcase
   end

   assign irq = status_w[ST_IRQ];
   assign drq = status_w[ST_DRQ];
endmodule

// File: rtl/dkc_host_port_chk.sv
module dkc_host_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] status,
   input logic       irq,
   input logic       drq,
   input logic       data_wr,
   input logic       data_rd,
   input logic       sel_wr
);
   // R2
   sel_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> (status[3:0] == 4'b1101) && !status[5]);

   // R3
   exec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[3] && !status[0]) |-> (status[2:1] == 2'b00) && !irq);

   // R4
   irq_in_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status[1] && status[0]));

   // R5
   drq_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drq |-> (status[3] && !status[0]));

   // R9
   stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[1] && data_rd && !sel_wr) |=> (status[1] || (status == 8'h00)));

   // R10
   stat_wr_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[1] && data_wr && !data_rd) |=> $stable(status));
endmodule

bind dkc_host_port dkc_host_port_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .status  (status_w),
   .irq     (irq),
   .drq     (drq),
   .data_wr (data_wr_w),
   .data_rd (data_rd_w),
   .sel_wr  (sel_wr_w)
);

// File: tb/dkc_host_port_bench.sv
module dkc_host_port_bench;
   localparam int CLK_PERIOD  = 10;
   localparam int EXEC_CYCLES = 8;
   localparam int NUM_SECTORS = 17;
   localparam int ECC_SECTOR  = 5;
   localparam int ECC_LEN     = 11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = 2'd1;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq, drq;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   dkc_host_port #(
      .EXEC_CYCLES (EXEC_CYCLES),
      .NUM_SECTORS (NUM_SECTORS),
      .ECC_SECTOR  (ECC_SECTOR),
      .ECC_LEN     (ECC_LEN)
   ) u_dkc_host_port (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .irq(irq), .drq(drq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference: 0 idle, 1 command, 2 execute, 3 results
   int         m_ph = 0;
   int         m_bcnt = 0;
   int         m_wait = 0;
   bit         m_irq = 0;
   bit [1:0]   m_mask = 0;
   byte        m_cmd [6];
   byte        m_res [$];
   int         m_lerr = 0;
   byte        m_larg [3] = '{0, 0, 0};

   function automatic bit m_rw();
      return (m_cmd[0] == 8'h08) || (m_cmd[0] == 8'h0A);
   endfunction

   function automatic void m_finish_op();
      int err = 0;
      int sec = m_cmd[2] & 8'h3F;
      m_res.delete();
      if (m_cmd[0] == 8'h03) begin
         m_res.push_back(8'(m_lerr));
         for (int i = 0; i < 3; i++) m_res.push_back(m_larg[i]);
         return;
      end
      if (m_cmd[0] == 8'h0D) begin
         m_res.push_back(8'(ECC_LEN));
         m_res.push_back(8'h00);
      end else begin
         if (m_cmd[0] == 8'h01 || m_cmd[0] == 8'h0C) err = 0;
         else if (m_rw()) begin
            if (sec >= NUM_SECTORS) err = 'h21;
            else if (m_cmd[0] == 8'h08 && sec == ECC_SECTOR) err = 'h18;
         end else err = 'h20;
         m_res.push_back(8'(err));
      end
      m_lerr = err;
      for (int i = 0; i < 3; i++) m_larg[i] = m_cmd[i+1];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_irq = 0; m_mask = 0; m_bcnt = 0; m_lerr = 0;
         m_larg = '{0, 0, 0};
         m_res.delete();
      end else begin
         if (wr_en && addr == 2'd2) begin
            m_ph = 1; m_bcnt = 0; m_irq = 0;
         end else if (m_ph == 1) begin
            if (wr_en && addr == 2'd0) begin
               m_cmd[m_bcnt] = wdata;
               m_bcnt++;
               if (m_bcnt == 6) begin m_ph = 2; m_wait = EXEC_CYCLES; end
            end
         end else if (m_ph == 2) begin
            m_wait--;
            if (m_wait == 0) begin
               m_finish_op();
               m_ph = 3; m_irq = m_mask[1];
            end
         end else if (m_ph == 3) begin
            if (rd_en && addr == 2'd0) begin
               void'(m_res.pop_front());
               if (m_res.size() == 0) begin m_ph = 0; m_irq = 0; end
            end
         end
         if (wr_en && addr == 2'd3) m_mask = wdata[1:0];
      end
   end

   function automatic byte m_status();
      byte s = 0;
      s[0] = (m_ph == 1 || m_ph == 3);
      s[1] = (m_ph == 3);
      s[2] = (m_ph == 1 || m_ph == 3);
      s[3] = (m_ph != 0);
      s[4] = (m_ph == 2) && m_mask[0] && m_rw();
      s[5] = m_irq;
      return s;
   endfunction

   function automatic byte m_rdata(logic [1:0] a);
      if (a == 2'd1) return m_status();
      if (a == 2'd0 && m_ph == 3) return m_res[0];
      return 8'h00;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // one bus cycle; lit >= 0 adds a directed check of rdata
   task automatic step(input logic [1:0] a, input logic w, input logic r,
                       input logic [7:0] d, input int lit, input string tag);
      byte st;
      @(negedge clk);
      addr = a; wr_en = w; rd_en = r; wdata = d;
      #1;
      st = m_status();
      check({tag, " rdata"}, rdata, m_rdata(a));
      check({tag, " irq"}, irq, st[5]);
      check({tag, " drq"}, drq, st[4]);
      if (lit >= 0) check({tag, " directed"}, rdata, lit);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(2'd1, 0, 0, 8'h00, -1, tag);
   endtask

   task automatic send(input byte b[6], input string tag);
      step(2'd2, 1, 0, 8'h00, -1, tag);
      step(2'd1, 0, 0, 8'h00, 8'h0D, "R2");
      for (int i = 0; i < 6; i++) step(2'd0, 1, 0, b[i], -1, tag);
   endtask

   task automatic wait_res(input string tag);
      for (int i = 0; i < 50 && m_ph != 3; i++) idle(1, tag);
   endtask

   task automatic rd_res(input int lit, input string tag);
      step(2'd0, 0, 1, 8'h00, lit, tag);
   endtask

   task automatic set_mask(input logic [7:0] v);
      step(2'd3, 1, 0, v, -1, "R4");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!ended) begin
         ended = 1;
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1
      step(2'd1, 0, 0, 8'h00, 8'h00, "R1");
      check("R1 irq", irq, 0);
      check("R1 drq", drq, 0);

      // R3 R4 R9: recalibrate, interrupt enabled
      set_mask(8'h02);
      send('{8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h05}, "R3");
      for (int i = 0; i < EXEC_CYCLES; i++) step(2'd1, 0, 0, 8'h00, 8'h08, "R3");
      step(2'd1, 0, 0, 8'h00, 8'h2F, "R4");
      rd_res(8'h00, "R6");
      step(2'd1, 0, 0, 8'h00, 8'h00, "R9");
      check("R9 irq", irq, 0);

      // R5: read with DMA and interrupt
      set_mask(8'h03);
      send('{8'h08, 8'h00, 8'h03, 8'h10, 8'h01, 8'h05}, "R5");
      step(2'd1, 0, 0, 8'h00, 8'h18, "R5");
      check("R5 drq pin", drq, 1);
      wait_res("R5");
      rd_res(8'h00, "R6");

      // R5 negative: recalibrate with DMA enabled gives no request
      send('{8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h05}, "R5");
      step(2'd1, 0, 0, 8'h00, 8'h08, "R5");
      wait_res("R5");
      rd_res(8'h00, "R5");

      // R6: sector out of range, unknown opcode, no interrupt
      set_mask(8'h00);
      send('{8'h0A, 8'h00, 8'd20, 8'h00, 8'h01, 8'h05}, "R6");
      for (int i = 0; i < EXEC_CYCLES; i++) step(2'd1, 0, 0, 8'h00, 8'h08, "R5");
      step(2'd1, 0, 0, 8'h00, 8'h0F, "R4");
      rd_res(8'h21, "R6");
      send('{8'h55, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, "R6");
      wait_res("R6");
      rd_res(8'h20, "R6");

      // R7: correctable error then ECC length read
      set_mask(8'h02);
      send('{8'h08, 8'h21, 8'h05, 8'h7A, 8'h01, 8'h05}, "R7");
      wait_res("R7");
      rd_res(8'h18, "R7");
      send('{8'h0D, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, "R7");
      wait_res("R7");
      rd_res(ECC_LEN, "R7");
      step(2'd1, 0, 0, 8'h00, 8'h2F, "R9");
      rd_res(8'h00, "R7");

      // R8: sense reports the ECC-length command (error 0, args 0)
      send('{8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, "R8");
      wait_res("R8");
      rd_res(8'h00, "R8");
      // R8 again after a failing read with distinct arguments
      send('{8'h08, 8'h21, 8'h05, 8'h7A, 8'h01, 8'h05}, "R8");
      wait_res("R8");
      rd_res(8'h18, "R8");
      send('{8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, "R8");
      wait_res("R8");
      // R10: stray data write in result phase, reads of offsets 2 and 3
      step(2'd0, 1, 0, 8'hEE, -1, "R10");
      step(2'd2, 0, 1, 8'h00, 8'h00, "R10");
      step(2'd3, 0, 1, 8'h00, 8'h00, "R10");
      rd_res(8'h18, "R8");
      rd_res(8'h21, "R9");
      rd_res(8'h05, "R8");
      step(2'd1, 0, 0, 8'h00, 8'h2F, "R9");
      rd_res(8'h7A, "R8");
      step(2'd1, 0, 0, 8'h00, 8'h00, "R9");

      // R10: data read in idle and in command phase has no effect
      rd_res(8'h00, "R10");
      step(2'd2, 1, 0, 8'h00, -1, "R2");
      step(2'd0, 1, 0, 8'h0C, -1, "R10");
      rd_res(8'h00, "R10");
      step(2'd1, 0, 0, 8'h00, 8'h0D, "R10");
      for (int i = 0; i < 5; i++) step(2'd0, 1, 0, 8'h00, -1, "R10");
      step(2'd1, 0, 0, 8'h00, 8'h08, "R3");

      // R2: select in the middle of execution aborts the work
      idle(3, "R2");
      step(2'd2, 1, 0, 8'h00, -1, "R2");
      step(2'd1, 0, 0, 8'h00, 8'h0D, "R2");
      idle(EXEC_CYCLES + 2, "R2");
      step(2'd1, 0, 0, 8'h00, 8'h0D, "R2");
      for (int i = 0; i < 6; i++) step(2'd0, 1, 0, (i == 0) ? 8'h0C : 8'h00, -1, "R2");
      wait_res("R2");
      step(2'd1, 0, 0, 8'h00, 8'h2F, "R4");
      // R2: select during the result phase also restarts and drops irq
      step(2'd2, 1, 0, 8'h00, -1, "R2");
      step(2'd1, 0, 0, 8'h00, 8'h0D, "R2");
      check("R2 irq dropped", irq, 0);
      idle(2, "R2");

      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule